// File: doc/BRIEF.md
# Function-Coded Arithmetic Logic Unit

This block is a purely combinational N-bit arithmetic logic unit. It takes two operands and a 3-bit function code and returns one result word and a zero indication. One adder does both addition and subtraction. The most significant bit of the function code makes the unit invert the second operand and forces a carry of one into the adder. The two low bits of the code then pick which result reaches the output: bitwise AND, bitwise OR, the adder sum, or a set-less-than value.

Because the inversion also feeds the logic operations, codes with the top bit set give AND-with-complement and OR-with-complement. Set-less-than returns the sign bit of the difference, moved to bit 0 with all higher bits cleared. The sign bit is used as it is, with no correction for signed overflow. Code 011 has no operation and returns zero. The unit sits inside a datapath stage and has no handshake. Its outputs follow its inputs within the same cycle.

Top module: `fcode_alu`

## Requirements
- R1: Function code 3'b000 gives Y = A & B.
- R2: Function code 3'b001 gives Y = A | B.
- R3: Function code 3'b010 gives Y = (A + B) modulo 2^W. A carry out of the top bit is dropped.
- R4: Function code 3'b110 gives Y = (A - B) modulo 2^W. This is A plus the inverted B plus a carry-in of one.
- R5: Function code 3'b100 gives Y = A & ~B.
- R6: Function code 3'b101 gives Y = A | ~B.
- R7: Function code 3'b111 gives Y[0] equal to bit W-1 of (A - B) modulo 2^W, with no overflow correction. For example, A=25 and B=32 give Y=1, and A=0x80000000 and B=1 give Y=0.
- R8: Under function code 3'b111, bits W-1 down to 1 of Y are all zero.
- R9: Function code 3'b011 gives Y = 0, whatever A and B are.
- R10: The zero output is 1 exactly when every bit of Y is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | W | First operand |
| b_in | input | W | Second operand, inverted when func[2] is 1 |
| func | input | 3 | Function code (bit 2 inverts B and sets the carry-in; bits 1:0 select the result) |
| y_out | output | W | Result word |
| zero_out | output | 1 | 1 when y_out is all zeros |

## Verification
Every result is combinational, so y_out and zero_out are due in the same cycle that a new operand pair and code are applied. No register lies on any path. The bench drives inputs on the falling clock edge and samples the outputs two nanoseconds later, well before the next rising edge, so no result depends on the order of events at an edge. Expected values come from a model of the function table in the bench. That model includes the raw sign-bit behaviour of set-less-than near signed overflow.

// File: rtl/fcode_alu_pkg.sv
package fcode_alu_pkg;
  // Result selector carried in the low two function bits
  typedef enum logic [1:0] {
    SEL_AND = 2'b00,
    SEL_OR  = 2'b01,
    SEL_SUM = 2'b10,
    SEL_SLT = 2'b11
  } res_sel_e;

  localparam logic [2:0] FUNC_UNUSED = 3'b011;
  localparam logic [2:0] FUNC_ADD    = 3'b010;
  localparam logic [2:0] FUNC_SUB    = 3'b110;
  localparam logic [2:0] FUNC_SLT    = 3'b111;
endpackage

// File: rtl/fcode_alu_operand.sv
module fcode_alu_operand #(
  parameter int W = 32
) (
  input  logic [W-1:0] b_raw,
  input  logic         invert,
  output logic [W-1:0] b_eff,
  output logic         carry_in
);
  always_comb begin
    b_eff    = invert ? ~b_raw : b_raw;
    carry_in = invert;
  end

  // R4: the inverted operand and the forced carry always travel together
  always_comb begin
    if (invert) begin
      a_r4_invert_pair: assert ((b_eff ^ b_raw) == {W{1'b1}} && carry_in);
    end else begin
      a_r3_pass_pair: assert (b_eff == b_raw && !carry_in);
    end
  end
endmodule

// File: rtl/fcode_alu_adder.sv
module fcode_alu_adder #(
  parameter int W      = 32,
  parameter bit RIPPLE = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum
);
  generate
    if (RIPPLE) begin : g_ripple
      logic [W:0] carry;
      assign carry[0] = cin;
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]     = a[i] ^ b[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
      end
    end else begin : g_behav
      assign sum = a + b + {{(W-1){1'b0}}, cin};
    end
  endgenerate
endmodule

// File: rtl/fcode_alu_select.sv
module fcode_alu_select #(
  parameter int W = 32
) (
  input  logic [2:0]   func,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b_eff,
  input  logic [W-1:0] sum,
  output logic [W-1:0] y
);
  import fcode_alu_pkg::*;
  localparam int PAD = W - 1;

  res_sel_e sel;
  assign sel = res_sel_e'(func[1:0]);

  always_comb begin
    if (func == FUNC_UNUSED) begin
      y = '0;
    end else begin
      unique case (sel)
        SEL_AND: y = a & b_eff;
        SEL_OR:  y = a | b_eff;
        SEL_SUM: y = sum;
        SEL_SLT: y = {{PAD{1'b0}}, sum[W-1]};
        default: y = '0;
      endcase
    end
  end

  // R8: the set-less-than form never sets any bit above bit 0
  always_comb begin
    if (func == FUNC_SLT) begin
      a_r8_slt_upper_clear: assert (y[W-1:1] == '0);
    end
  end
endmodule

// File: rtl/fcode_alu.sv
module fcode_alu #(
  parameter int W      = 32,
  parameter bit RIPPLE = 1'b1
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [2:0]   func,
  output logic [W-1:0] y_out,
  output logic         zero_out
);
  import fcode_alu_pkg::*;

  logic [W-1:0] b_eff;
  logic         cin;
  logic [W-1:0] sum;

  fcode_alu_operand #(.W(W)) u_operand (
    .b_raw    (b_in),
    .invert   (func[2]),
    .b_eff    (b_eff),
    .carry_in (cin)
  );

  fcode_alu_adder #(.W(W), .RIPPLE(RIPPLE)) u_adder (
    .a   (a_in),
    .b   (b_eff),
    .cin (cin),
    .sum (sum)
  );

  fcode_alu_select #(.W(W)) u_select (
    .func  (func),
    .a     (a_in),
    .b_eff (b_eff),
    .sum   (sum),
    .y     (y_out)
  );

  assign zero_out = ~|y_out;

  // Checks relating the shared adder and the selector to the ports
  always_comb begin
    if (func == FUNC_ADD) begin
      a_r3_add_result: assert (y_out == W'(a_in + b_in));
    end
    if (func == FUNC_SUB) begin
      a_r4_sub_result: assert (y_out == W'(a_in - b_in));
    end
    if (func == FUNC_UNUSED) begin
      a_r9_unused_zero: assert (y_out == '0 && zero_out);
    end
    if (func == FUNC_SLT) begin
      a_r10_slt_zero_flag: assert (zero_out == ~sum[W-1]);
    end
  end
endmodule

// File: tb/fcode_alu_bench.sv
module fcode_alu_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic [2:0]   func = 3'b000;
  logic [W-1:0] y_out;
  logic         zero_out;
  int           n_chk = 0;
  int           n_bad = 0;
  bit           done  = 1'b0;

  always #4 clk = ~clk;

  fcode_alu #(.W(W)) u_fcode_alu (
    .a_in(a_in), .b_in(b_in), .func(func), .y_out(y_out), .zero_out(zero_out)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic [2:0] f);
    logic [W-1:0] d;
    d = a - b;
    case (f)
      3'b000: return a & b;
      3'b001: return a | b;
      3'b010: return a + b;
      3'b100: return a & ~b;
      3'b101: return a | ~b;
      3'b110: return d;
      3'b111: return {{(W-1){1'b0}}, d[W-1]};
      default: return '0;
    endcase
  endfunction

  task automatic run(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic [2:0] f);
    logic [W-1:0] exp_y;
    @(negedge clk);
    a_in = a; b_in = b; func = f;
    #2;
    exp_y = model(a, b, f);
    n_chk++;
    if (y_out !== exp_y) begin
      n_bad++;
      $display("FAIL %s func=%b y actual=%h expected=%h", req, f, y_out, exp_y);
    end
    n_chk++;
    if (zero_out !== (exp_y == '0)) begin
      n_bad++;
      $display("FAIL R10 func=%b zero actual=%b expected=%b", f, zero_out, exp_y == '0);
    end
  endtask

  task automatic t_idle();     run("R1", '0, '0, 3'b000); endtask
  task automatic t_logic();
    run("R1", 32'hF0F0_A5A5, 32'hFF00_0FF0, 3'b000);
    run("R2", 32'hF0F0_A5A5, 32'h0F00_0FF0, 3'b001);
    run("R5", 32'hF0F0_A5A5, 32'hFF00_0FF0, 3'b100);
    run("R6", 32'h0000_1234, 32'hFFFF_0000, 3'b101);
  endtask
  task automatic t_arith();
    run("R3", 32'd1234, 32'd4321, 3'b010);
    run("R3", 32'hFFFF_FFFF, 32'd1, 3'b010);
    run("R4", 32'd10, 32'd3, 3'b110);
    run("R4", 32'd3, 32'd10, 3'b110);
    run("R4", 32'h5555_5555, 32'h5555_5555, 3'b110);
  endtask
  task automatic t_slt();
    run("R7", 32'd25, 32'd32, 3'b111);
    run("R7", 32'd32, 32'd25, 3'b111);
    run("R7", 32'd7, 32'd7, 3'b111);
    run("R7", 32'h8000_0000, 32'd1, 3'b111);
    run("R8", 32'hFFFF_FFFE, 32'h0000_0001, 3'b111);
  endtask
  task automatic t_unused();
    run("R9", 32'hDEAD_BEEF, 32'h1234_5678, 3'b011);
    run("R9", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011);
  endtask

  initial begin
    #20 rst_n = 1'b1;
    t_idle();
    t_logic();
    t_arith();
    t_slt();
    t_unused();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule